// File: doc/BRIEF.md
# Wavefront Issue Readiness Checker

This block watches one wavefront slot of a compute unit. Each cycle it decides whether the oldest instruction held in that slot's instruction buffer may go to the scheduler. The wavefront's status word, its counters and flags, and a bit vector that classifies the next instruction all feed a fixed chain of gates. The first gate that fails supplies a single stall reason. When every gate passes, the block raises `issue_rdy` and names the execution resource that the instruction needs.

Gating on status comes first: a pending wait on memory counters, a sleep, or a barrier. Only after that does the block look at whether the buffer holds anything. This order lets a wavefront resume once its condition clears, even when the instruction that caused the wait was the last one in the buffer. An end-of-program instruction waits until it is the oldest entry in the buffer. The block then asks the wavefront to set zero wait targets and holds the instruction back until every outstanding counter has drained.

The verdict, reason code and resource index are combinational. The barrier release strobe, with its barrier ID, and the implicit-wait request are registered. Each appears one cycle after the condition that causes it.

Top module: `wf_issue_ready`

## Requirements
- R1: With `wf_status` = 1 (waiting on counters) and `wait_sat` low, the block reports reason 3 and is not ready, whatever the buffer, class and operand inputs are. With `wait_sat` high the remaining checks decide.
- R2: With `wf_status` = 2 (sleeping) and `sleep_done` low, the block reports reason 7 and is not ready. With `sleep_done` high the remaining checks decide.
- R3: With `wf_status` = 3 (at a barrier) and `bar_all` low, the block reports reason 4. With `bar_all` high, the remaining checks decide in the same cycle, and one cycle later `bar_rel` is high for one cycle with `bar_rel_id` equal to the `bar_id` of that cycle.
- R4: `wf_status` values 4, 5, 6 and 7 (stopped, returning, stalled, parked) report reason 1 and are not ready.
- R5: A status that passes, combined with `ib_empty` high or `nxt_valid` low, reports reason 2.
- R6: The bits of `nxt_class` are: 0 ALU, 1 branch, 2 nop, 3 return, 4 end-of-program, 5 barrier, 6 load, 7 store, 8 atomic, 9 memory sync, 10 flat, 11 flat-global, 12 sleep, 13 scalar, 14 local memory, 15 global memory, 16 kernel argument, 17 argument segment. Two cases raise `class_err` and report reason 0, never ready:
  - a class in which none of bits 0 to 12 is set; this check comes before the operand checks;
  - a class that passes every check but maps to no resource.
- R7: A non-scalar instruction with `vreg_rdy` low reports reason 5. A scalar instruction ignores `vreg_rdy`.
- R8: Any instruction with `sreg_rdy` low, once the earlier checks pass, reports reason 6.
- R9: An end-of-program instruction reports reason 3 while `nxt_oldest` is low. Once it is oldest:
  - it is ready only when `cnt_zero` is high, and otherwise reports reason 3;
  - `eop_wait_req` goes high in the next cycle.
- R10: Resources for memory classes, in order of precedence:
  - flat goes to the global-memory unit (`NUM_SIMD`+1);
  - local memory goes to the local-memory unit (`NUM_SIMD`+2);
  - global memory goes to the global-memory unit when vector and to the scalar-memory unit (`NUM_SIMD`+3) when scalar.
- R11: The following classes go to `simd_id` when vector and to the scalar ALU (`NUM_SIMD`) when scalar: branch, ALU, kernel-argument load, argument segment, return, end-of-program, nop and barrier.
- R12: When ready, `stall_code` is 8 and `res_idx` holds the mapped resource. When not ready, `res_idx` is 0. The checks run in this order, and the first failure sets the code:
  1. counter wait
  2. sleep
  3. barrier
  4. stop
  5. buffer
  6. class
  7. vector operands
  8. scalar operands
  9. end-of-program
- R13: While `rst_n` is low, `bar_rel`, `bar_rel_id` and `eop_wait_req` are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset for the registered strobes |
| wf_status | input | 3 | Wavefront status code |
| wait_sat | input | 1 | Wait-counter targets are met |
| sleep_done | input | 1 | Sleep period has expired |
| bar_all | input | 1 | All wavefronts have arrived at this barrier |
| bar_id | input | BAR_W | Barrier this wavefront waits on |
| simd_id | input | RES_W | SIMD index that owns the wavefront |
| ib_empty | input | 1 | Instruction buffer is empty |
| nxt_valid | input | 1 | An undispatched next instruction exists |
| nxt_class | input | 18 | Class bits of the next instruction |
| nxt_oldest | input | 1 | Next instruction is the oldest buffer entry |
| vreg_rdy | input | 1 | Vector operands are ready |
| sreg_rdy | input | 1 | Scalar operands are ready |
| cnt_zero | input | 1 | All outstanding counters are zero |
| issue_rdy | output | 1 | Instruction may issue this cycle |
| stall_code | output | 4 | Reason code, 8 when ready |
| res_idx | output | RES_W | Target execution resource |
| class_err | output | 1 | Unrecognised or unmappable class |
| bar_rel | output | 1 | Registered barrier reset/release strobe |
| bar_rel_id | output | BAR_W | Barrier ID that goes with `bar_rel` |
| eop_wait_req | output | 1 | Registered request for zero wait targets |

## Verification
The bench builds the block with `NUM_SIMD` = 4, so `RES_W` is 3 and every resource index from 0 to 7 appears on the port. The scalar-memory unit sits at 7, the top of the field, so an off-by-one in the resource offsets shows up as a wrong index. It drives `simd_id` to 2, which differs from the scalar ALU index 4, so a swapped vector/scalar choice cannot go unnoticed. `BAR_W` = 4 lets the release strobe carry a non-zero barrier ID that the bench can compare after the register stage.

// File: rtl/wf_rdy_pkg.sv
package wf_rdy_pkg;

    typedef enum logic [2:0] {
        WST_RUN      = 3'd0,
        WST_WAITCNT  = 3'd1,
        WST_SLEEP    = 3'd2,
        WST_BARRIER  = 3'd3,
        WST_STOPPED  = 3'd4,
        WST_RETURN   = 3'd5,
        WST_STALLED  = 3'd6,
        WST_PARKED   = 3'd7
    } wf_state_e;

    typedef enum logic [3:0] {
        RSN_ILLEGAL  = 4'd0,
        RSN_STOP     = 4'd1,
        RSN_IB_EMPTY = 4'd2,
        RSN_WAITCNT  = 4'd3,
        RSN_BARRIER  = 4'd4,
        RSN_VREG     = 4'd5,
        RSN_SREG     = 4'd6,
        RSN_SLEEP    = 4'd7,
        RSN_READY    = 4'd8
    } stall_rsn_e;

    localparam int CLS_W       = 18;
    localparam int CB_ALU      = 0;
    localparam int CB_BRANCH   = 1;
    localparam int CB_NOP      = 2;
    localparam int CB_RETURN   = 3;
    localparam int CB_EOP      = 4;
    localparam int CB_BARRIER  = 5;
    localparam int CB_LOAD     = 6;
    localparam int CB_STORE    = 7;
    localparam int CB_ATOMIC   = 8;
    localparam int CB_MEMSYNC  = 9;
    localparam int CB_FLAT     = 10;
    localparam int CB_FLATGLB  = 11;
    localparam int CB_SLEEP    = 12;
    localparam int CB_SCALAR   = 13;
    localparam int CB_LOCAL    = 14;
    localparam int CB_GLOBAL   = 15;
    localparam int CB_KERNARG  = 16;
    localparam int CB_ARGSEG   = 17;

    // Bits 0..12 name instruction kinds; at least one must be set.
    localparam int KIND_BITS   = CB_SLEEP + 1;

endpackage

// File: rtl/wf_status_gate.sv
module wf_status_gate
    import wf_rdy_pkg::*;
(
    input  logic [2:0]  status,
    input  logic        wait_sat,
    input  logic        sleep_done,
    input  logic        bar_all,
    output logic        pass,
    output stall_rsn_e  rsn,
    output logic        bar_fire
);

    wf_state_e st;

    always_comb begin
        st       = wf_state_e'(status);
        pass     = 1'b1;
        rsn      = RSN_READY;
        bar_fire = 1'b0;
        case (st)
            WST_WAITCNT: begin
                if (!wait_sat) begin
                    pass = 1'b0;
                    rsn  = RSN_WAITCNT;
                end
            end
            WST_SLEEP: begin
                if (!sleep_done) begin
                    pass = 1'b0;
                    rsn  = RSN_SLEEP;
                end
            end
            WST_BARRIER: begin
                if (!bar_all) begin
                    pass = 1'b0;
                    rsn  = RSN_BARRIER;
                end else begin
                    // release the barrier and keep evaluating this cycle
                    bar_fire = 1'b1;
                end
            end
            WST_STOPPED, WST_RETURN, WST_STALLED, WST_PARKED: begin
                pass = 1'b0;
                rsn  = RSN_STOP;
            end
            default: begin
                pass = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/wf_inst_gate.sv
module wf_inst_gate
    import wf_rdy_pkg::*;
(
    input  logic        ib_empty,
    input  logic        nxt_valid,
    input  logic        known,
    input  logic        is_scalar,
    input  logic        is_eop,
    input  logic        oldest,
    input  logic        vreg_rdy,
    input  logic        sreg_rdy,
    input  logic        cnt_zero,
    output logic        pass,
    output stall_rsn_e  rsn,
    output logic        kind_err,
    output logic        eop_hit
);

    always_comb begin
        pass     = 1'b0;
        rsn      = RSN_READY;
        kind_err = 1'b0;
        eop_hit  = 1'b0;
        if (ib_empty || !nxt_valid) begin
            rsn = RSN_IB_EMPTY;
        end else if (!known) begin
            rsn      = RSN_ILLEGAL;
            kind_err = 1'b1;
        end else if (!is_scalar && !vreg_rdy) begin
            rsn = RSN_VREG;
        end else if (!sreg_rdy) begin
            rsn = RSN_SREG;
        end else if (is_eop && !oldest) begin
            // older entries must drain first
            rsn = RSN_WAITCNT;
        end else if (is_eop && !cnt_zero) begin
            eop_hit = 1'b1;
            rsn     = RSN_WAITCNT;
        end else begin
            eop_hit = is_eop;
            pass    = 1'b1;
        end
    end

endmodule

// File: rtl/wf_res_map.sv
module wf_res_map #(
    parameter int NUM_SIMD = 4,
    parameter int RES_W    = $clog2(NUM_SIMD + 4)
) (
    input  logic             is_flat,
    input  logic             is_local,
    input  logic             is_global,
    input  logic             is_scalar,
    input  logic             is_compute,
    input  logic [RES_W-1:0] simd_id,
    output logic             mapped,
    output logic [RES_W-1:0] res
);

    localparam logic [RES_W-1:0] SALU_IDX = RES_W'(NUM_SIMD);
    localparam logic [RES_W-1:0] GMEM_IDX = RES_W'(NUM_SIMD + 1);
    localparam logic [RES_W-1:0] LMEM_IDX = RES_W'(NUM_SIMD + 2);
    localparam logic [RES_W-1:0] SMEM_IDX = RES_W'(NUM_SIMD + 3);

    always_comb begin
        mapped = 1'b1;
        res    = '0;
        if (is_flat) begin
            res = GMEM_IDX;
        end else if (is_local) begin
            res = LMEM_IDX;
        end else if (is_global) begin
            res = is_scalar ? SMEM_IDX : GMEM_IDX;
        end else if (is_compute) begin
            res = is_scalar ? SALU_IDX : simd_id;
        end else begin
            mapped = 1'b0;
        end
    end

endmodule

// File: rtl/wf_issue_ready.sv
module wf_issue_ready
    import wf_rdy_pkg::*;
#(
    parameter int NUM_SIMD = 4,
    parameter int RES_W    = $clog2(NUM_SIMD + 4),
    parameter int BAR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        wf_status,
    input  logic              wait_sat,
    input  logic              sleep_done,
    input  logic              bar_all,
    input  logic [BAR_W-1:0]  bar_id,
    input  logic [RES_W-1:0]  simd_id,
    input  logic              ib_empty,
    input  logic              nxt_valid,
    input  logic [17:0]       nxt_class,
    input  logic              nxt_oldest,
    input  logic              vreg_rdy,
    input  logic              sreg_rdy,
    input  logic              cnt_zero,
    output logic              issue_rdy,
    output logic [3:0]        stall_code,
    output logic [RES_W-1:0]  res_idx,
    output logic              class_err,
    output logic              bar_rel,
    output logic [BAR_W-1:0]  bar_rel_id,
    output logic              eop_wait_req
);

    typedef struct packed {
        logic             bar_rel;
        logic [BAR_W-1:0] bar_id;
        logic             eop_req;
    } pulse_t;

    pulse_t pls_d, pls_q;

    logic       st_pass, st_fire;
    stall_rsn_e st_rsn;
    logic       in_pass, in_err, in_eop;
    stall_rsn_e in_rsn;
    logic       map_ok;
    logic [RES_W-1:0] map_res;
    logic       kind_known, kind_compute;

    // class decode
    always_comb begin
        kind_known   = |nxt_class[KIND_BITS-1:0];
        kind_compute = nxt_class[CB_BRANCH] | nxt_class[CB_ALU]
                     | (nxt_class[CB_KERNARG] & nxt_class[CB_LOAD])
                     | nxt_class[CB_ARGSEG] | nxt_class[CB_RETURN]
                     | nxt_class[CB_EOP] | nxt_class[CB_NOP]
                     | nxt_class[CB_BARRIER];
    end

    wf_status_gate u_status (
        .status     (wf_status),
        .wait_sat   (wait_sat),
        .sleep_done (sleep_done),
        .bar_all    (bar_all),
        .pass       (st_pass),
        .rsn        (st_rsn),
        .bar_fire   (st_fire)
    );

    wf_inst_gate u_inst (
        .ib_empty  (ib_empty),
        .nxt_valid (nxt_valid),
        .known     (kind_known),
        .is_scalar (nxt_class[CB_SCALAR]),
        .is_eop    (nxt_class[CB_EOP]),
        .oldest    (nxt_oldest),
        .vreg_rdy  (vreg_rdy),
        .sreg_rdy  (sreg_rdy),
        .cnt_zero  (cnt_zero),
        .pass      (in_pass),
        .rsn       (in_rsn),
        .kind_err  (in_err),
        .eop_hit   (in_eop)
    );

    wf_res_map #(
        .NUM_SIMD (NUM_SIMD),
        .RES_W    (RES_W)
    ) u_map (
        .is_flat    (nxt_class[CB_FLAT]),
        .is_local   (nxt_class[CB_LOCAL]),
        .is_global  (nxt_class[CB_GLOBAL]),
        .is_scalar  (nxt_class[CB_SCALAR]),
        .is_compute (kind_compute),
        .simd_id    (simd_id),
        .mapped     (map_ok),
        .res        (map_res)
    );

    // verdict and next strobe values
    always_comb begin
        issue_rdy  = 1'b0;
        stall_code = RSN_ILLEGAL;
        res_idx    = '0;
        class_err  = 1'b0;
        if (!st_pass) begin
            stall_code = st_rsn;
        end else if (!in_pass) begin
            stall_code = in_rsn;
            class_err  = in_err;
        end else if (!map_ok) begin
            stall_code = RSN_ILLEGAL;
            class_err  = 1'b1;
        end else begin
            issue_rdy  = 1'b1;
            stall_code = RSN_READY;
            res_idx    = map_res;
        end

        pls_d.bar_rel = st_fire;
        pls_d.bar_id  = st_fire ? bar_id : '0;
        pls_d.eop_req = st_pass & in_eop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pls_q <= '0;
        end else begin
            pls_q <= pls_d;
        end
    end

    assign bar_rel      = pls_q.bar_rel;
    assign bar_rel_id   = pls_q.bar_id;
    assign eop_wait_req = pls_q.eop_req;

endmodule

// File: rtl/wf_issue_chk.sv
module wf_issue_chk #(
    parameter int BAR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       wf_status,
    input logic             wait_sat,
    input logic             bar_all,
    input logic [BAR_W-1:0] bar_id,
    input logic             ib_empty,
    input logic             nxt_valid,
    input logic             cls_scalar,
    input logic             cls_eop,
    input logic             nxt_oldest,
    input logic             vreg_rdy,
    input logic             sreg_rdy,
    input logic             issue_rdy,
    input logic [3:0]       stall_code,
    input logic             class_err,
    input logic             bar_rel,
    input logic [BAR_W-1:0] bar_rel_id,
    input logic             eop_wait_req
);

    assert_wait_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wf_status == 3'd1 && !wait_sat) |-> (!issue_rdy && stall_code == 4'd3));

    assert_bar_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bar_rel |-> $past(wf_status == 3'd3 && bar_all));

    assert_bar_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bar_rel |-> (bar_rel_id == $past(bar_id)));

    assert_empty_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_empty || !nxt_valid) |-> !issue_rdy);

    assert_err_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        class_err |-> (!issue_rdy && stall_code == 4'd0));

    assert_vreg_needed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_rdy && !cls_scalar) |-> vreg_rdy);

    assert_sreg_needed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_rdy |-> sreg_rdy);

    assert_eop_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eop_wait_req |-> $past(cls_eop && nxt_oldest && nxt_valid && !ib_empty));

    assert_ready_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        issue_rdy |-> (stall_code == 4'd8 && !class_err));

endmodule

bind wf_issue_ready wf_issue_chk #(.BAR_W(BAR_W)) u_issue_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wf_status    (wf_status),
    .wait_sat     (wait_sat),
    .bar_all      (bar_all),
    .bar_id       (bar_id),
    .ib_empty     (ib_empty),
    .nxt_valid    (nxt_valid),
    .cls_scalar   (nxt_class[13]),
    .cls_eop      (nxt_class[4]),
    .nxt_oldest   (nxt_oldest),
    .vreg_rdy     (vreg_rdy),
    .sreg_rdy     (sreg_rdy),
    .issue_rdy    (issue_rdy),
    .stall_code   (stall_code),
    .class_err    (class_err),
    .bar_rel      (bar_rel),
    .bar_rel_id   (bar_rel_id),
    .eop_wait_req (eop_wait_req)
);

// File: tb/test_wf_issue_ready.sv
module test_wf_issue_ready;

    localparam int NS  = 4;
    localparam int RW  = 3;
    localparam int BW  = 4;

    localparam logic [17:0] K_ALU = 18'h00001, K_BR  = 18'h00002, K_NOP = 18'h00004,
                            K_RET = 18'h00008, K_EOP = 18'h00010, K_BAR = 18'h00020,
                            K_LD  = 18'h00040, K_ST  = 18'h00080, K_SLP = 18'h01000,
                            K_FL  = 18'h00400, K_SC  = 18'h02000, K_LM  = 18'h04000,
                            K_GM  = 18'h08000, K_KA  = 18'h10000, K_AS  = 18'h20000;

    typedef struct packed {
        logic [3:0]  tag;
        logic [2:0]  st;
        logic        ws, sd, ba, ibe, nv;
        logic [17:0] cls;
        logic        old, vr, sr, cz;
        logic        e_rdy;
        logic [3:0]  e_code;
        logic [2:0]  e_res;
        logic        e_err;
    } vec_t;

    function automatic vec_t v(int tag, int st, int ws, int sd, int ba, int ibe, int nv,
                               logic [17:0] cls, int old, int vr, int sr, int cz,
                               int rdy, int code, int res, int err);
        vec_t r;
        r.tag = 4'(tag); r.st = 3'(st);
        r.ws = ws[0]; r.sd = sd[0]; r.ba = ba[0]; r.ibe = ibe[0]; r.nv = nv[0];
        r.cls = cls; r.old = old[0]; r.vr = vr[0]; r.sr = sr[0]; r.cz = cz[0];
        r.e_rdy = rdy[0]; r.e_code = 4'(code); r.e_res = 3'(res); r.e_err = err[0];
        return r;
    endfunction

    localparam int NV = 41;
    localparam vec_t VEC [NV] = '{
        // R12 vector ALU ready on its own SIMD; R11 scalar ALU
        v(12,0,1,1,1,0,1,K_ALU,       1,1,1,1, 1,8,2,0),
        v(11,0,1,1,1,0,1,K_ALU|K_SC,  1,1,1,1, 1,8,4,0),
        // R10 memory mapping
        v(10,0,1,1,1,0,1,K_FL|K_LD,   1,1,1,1, 1,8,5,0),
        v(10,0,1,1,1,0,1,K_LM|K_LD,   1,1,1,1, 1,8,6,0),
        v(10,0,1,1,1,0,1,K_GM|K_ST,   1,1,1,1, 1,8,5,0),
        v(10,0,1,1,1,0,1,K_GM|K_LD|K_SC,1,1,1,1,1,8,7,0),
        v(10,0,1,1,1,0,1,K_FL|K_SC|K_LD,1,1,1,1,1,8,5,0),
        // R11 compute group
        v(11,0,1,1,1,0,1,K_KA|K_LD|K_SC,1,1,1,1,1,8,4,0),
        v(11,0,1,1,1,0,1,K_BR,        1,1,1,1, 1,8,2,0),
        v(11,0,1,1,1,0,1,K_NOP|K_SC,  1,1,1,1, 1,8,4,0),
        v(11,0,1,1,1,0,1,K_BAR,       1,1,1,1, 1,8,2,0),
        v(11,0,1,1,1,0,1,K_AS|K_LD,   1,1,1,1, 1,8,2,0),
        v(11,0,1,1,1,0,1,K_RET|K_SC,  1,1,1,1, 1,8,4,0),
        // R1 counter wait beats an empty buffer
        v(1, 1,0,1,1,1,0,K_ALU,       1,1,1,1, 0,3,0,0),
        v(1, 1,1,1,1,0,1,K_ALU,       1,1,1,1, 1,8,2,0),
        v(1, 1,0,0,0,0,1,K_ALU,       1,1,1,1, 0,3,0,0),
        // R2 sleep
        v(2, 2,0,0,1,1,1,K_ALU,       1,1,1,1, 0,7,0,0),
        v(2, 2,1,1,1,0,1,K_ALU,       1,1,1,1, 1,8,2,0),
        v(2, 0,0,0,0,0,1,K_ALU,       1,1,1,1, 1,8,2,0),
        // R3 barrier
        v(3, 3,1,1,0,1,1,K_ALU,       1,1,1,1, 0,4,0,0),
        v(3, 3,1,1,1,0,1,K_ALU|K_SC,  1,1,1,1, 1,8,4,0),
        // R4 halted statuses
        v(4, 4,1,1,1,0,1,K_ALU,       1,1,1,1, 0,1,0,0),
        v(4, 5,1,1,1,0,1,K_ALU,       1,1,1,1, 0,1,0,0),
        v(4, 6,1,1,1,0,1,K_ALU,       1,1,1,1, 0,1,0,0),
        v(4, 7,1,1,1,0,1,K_ALU,       1,1,1,1, 0,1,0,0),
        // R5 buffer
        v(5, 0,1,1,1,1,1,K_ALU,       1,1,1,1, 0,2,0,0),
        v(5, 0,1,1,1,0,0,K_ALU,       1,1,1,1, 0,2,0,0),
        // R6 unknown / unmapped classes
        v(6, 0,1,1,1,0,1,18'h0,       1,1,1,1, 0,0,0,1),
        v(6, 0,1,1,1,0,1,K_SC,        1,1,1,1, 0,0,0,1),
        v(6, 0,1,1,1,0,1,K_ST,        1,1,1,1, 0,0,0,1),
        v(6, 0,1,1,1,0,1,K_SLP,       1,1,1,1, 0,0,0,1),
        v(6, 0,1,1,1,0,1,18'h0,       1,0,0,1, 0,0,0,1),
        // R7 vector operands
        v(7, 0,1,1,1,0,1,K_ALU,       1,0,1,1, 0,5,0,0),
        v(7, 0,1,1,1,0,1,K_ALU|K_SC,  1,0,1,1, 1,8,4,0),
        // R8 scalar operands
        v(8, 0,1,1,1,0,1,K_ALU,       1,1,0,1, 0,6,0,0),
        v(8, 0,1,1,1,0,1,K_ALU,       1,0,0,1, 0,5,0,0),
        // R9 end of program
        v(9, 0,1,1,1,0,1,K_EOP,       0,1,1,1, 0,3,0,0),
        v(9, 0,1,1,1,0,1,K_EOP,       1,1,1,0, 0,3,0,0),
        v(9, 0,1,1,1,0,1,K_EOP,       1,1,1,1, 1,8,2,0),
        v(9, 0,1,1,1,0,1,K_EOP|K_SC,  1,1,1,1, 1,8,4,0),
        // R12 priority: stop beats empty buffer
        v(12,4,1,1,1,1,0,K_ALU,       1,1,1,1, 0,1,0,0)
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0]    wf_status = '0;
    logic          wait_sat = 1'b1, sleep_done = 1'b1, bar_all = 1'b1;
    logic [BW-1:0] bar_id = '0;
    logic [RW-1:0] simd_id = 3'd2;
    logic          ib_empty = 1'b0, nxt_valid = 1'b1;
    logic [17:0]   nxt_class = K_ALU;
    logic          nxt_oldest = 1'b1, vreg_rdy = 1'b1, sreg_rdy = 1'b1, cnt_zero = 1'b1;
    logic          issue_rdy, class_err, bar_rel, eop_wait_req;
    logic [3:0]    stall_code;
    logic [RW-1:0] res_idx;
    logic [BW-1:0] bar_rel_id;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wf_issue_ready #(.NUM_SIMD(NS), .RES_W(RW), .BAR_W(BW)) i_wf_issue_ready (
        .clk(clk), .rst_n(rst_n), .wf_status(wf_status), .wait_sat(wait_sat),
        .sleep_done(sleep_done), .bar_all(bar_all), .bar_id(bar_id), .simd_id(simd_id),
        .ib_empty(ib_empty), .nxt_valid(nxt_valid), .nxt_class(nxt_class),
        .nxt_oldest(nxt_oldest), .vreg_rdy(vreg_rdy), .sreg_rdy(sreg_rdy),
        .cnt_zero(cnt_zero), .issue_rdy(issue_rdy), .stall_code(stall_code),
        .res_idx(res_idx), .class_err(class_err), .bar_rel(bar_rel),
        .bar_rel_id(bar_rel_id), .eop_wait_req(eop_wait_req)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic idle_inputs();
        wf_status = 3'd0; wait_sat = 1'b1; sleep_done = 1'b1; bar_all = 1'b1;
        bar_id = '0; ib_empty = 1'b0; nxt_valid = 1'b1; nxt_class = K_ALU;
        nxt_oldest = 1'b1; vreg_rdy = 1'b1; sreg_rdy = 1'b1; cnt_zero = 1'b1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R13: strobes stay low while reset is held, even with causes present
        @(negedge clk);
        wf_status = 3'd3; bar_all = 1'b1; bar_id = 4'd9;
        @(posedge clk); #1;
        chk("R13", "bar_rel in reset", int'(bar_rel), 0);
        chk("R13", "bar_rel_id in reset", int'(bar_rel_id), 0);
        @(negedge clk);
        wf_status = 3'd0; nxt_class = K_EOP;
        @(posedge clk); #1;
        chk("R13", "eop_wait_req in reset", int'(eop_wait_req), 0);
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R13", "bar_rel after reset", int'(bar_rel), 0);

        // table walk: combinational verdict
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wf_status = VEC[i].st; wait_sat = VEC[i].ws; sleep_done = VEC[i].sd;
            bar_all = VEC[i].ba; ib_empty = VEC[i].ibe; nxt_valid = VEC[i].nv;
            nxt_class = VEC[i].cls; nxt_oldest = VEC[i].old; vreg_rdy = VEC[i].vr;
            sreg_rdy = VEC[i].sr; cnt_zero = VEC[i].cz;
            #1;
            chk($sformatf("R%0d", VEC[i].tag), $sformatf("vec%0d issue_rdy", i),
                int'(issue_rdy), int'(VEC[i].e_rdy));
            chk($sformatf("R%0d", VEC[i].tag), $sformatf("vec%0d stall_code", i),
                int'(stall_code), int'(VEC[i].e_code));
            chk($sformatf("R%0d", VEC[i].tag), $sformatf("vec%0d res_idx", i),
                int'(res_idx), int'(VEC[i].e_res));
            chk($sformatf("R%0d", VEC[i].tag), $sformatf("vec%0d class_err", i),
                int'(class_err), int'(VEC[i].e_err));
        end

        // R3: barrier release strobe with ID, one cycle later, single pulse
        @(negedge clk);
        idle_inputs();
        wf_status = 3'd3; bar_all = 1'b1; bar_id = 4'd5;
        #1;
        chk("R3", "ready same cycle as release", int'(issue_rdy), 1);
        @(posedge clk); #1;
        chk("R3", "bar_rel pulse", int'(bar_rel), 1);
        chk("R3", "bar_rel_id", int'(bar_rel_id), 5);
        @(negedge clk);
        bar_all = 1'b0;
        @(posedge clk); #1;
        chk("R3", "no release while waiting", int'(bar_rel), 0);

        // R9: implicit wait request
        @(negedge clk);
        idle_inputs();
        nxt_class = K_EOP; nxt_oldest = 1'b1; cnt_zero = 1'b0;
        @(posedge clk); #1;
        chk("R9", "eop_wait_req when oldest", int'(eop_wait_req), 1);
        @(negedge clk);
        nxt_oldest = 1'b0;
        @(posedge clk); #1;
        chk("R9", "no eop_wait_req when not oldest", int'(eop_wait_req), 0);
        @(negedge clk);
        nxt_oldest = 1'b1; wf_status = 3'd4;
        @(posedge clk); #1;
        chk("R4", "no eop_wait_req when stopped", int'(eop_wait_req), 0);
        @(negedge clk);
        idle_inputs();
        @(posedge clk); #1;
        chk("R9", "eop_wait_req drops for ALU", int'(eop_wait_req), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule